// File: doc/BRIEF.md
# Loop Status Qualifier with Battery Switch Control

This block sits between the loop-supervision comparator of an analog line interface and the line-card controller. The comparator output is asynchronous, active low and noisy. Glitches appear around every change of line state. A battery polarity reversal can hold a false loop-closure indication for up to 50 ms. The width of the glitch at ring entry or exit depends on the phase of the ringing waveform. The block synchronises the raw signal and rejects short disturbances with a debounce filter. It freezes its filtered hook status for a fixed worst-case blanking window each time the controller reports a line-state change. The filtered status is the only hook information the controller needs to read.

The block also decides when the line may move from the high battery to the low auxiliary battery. Ringing, scan and on-hook transmission all run on the high battery. Only a confirmed off-hook that stays unbroken for a long hold (500 ms by default) selects the low battery. Dial-pulse breaks therefore never toggle the battery switch. Any confirmed return to on-hook releases the low battery at once and rearms the hold. All windows are given in milliseconds and scaled by a clocks-per-millisecond parameter.

Top module: `line_hook_qual`

## Requirements
- R1: While reset is asserted and right after it, the filtered hook status reads on-hook (0), the off-hook event is 0 and the low-battery select is 0.
- R2: The raw loop input is active low: 0 means loop current, which is off-hook. It passes through SYNC_STAGES flops. The filtered status (1 = off-hook) takes a new raw level only after that level has differed from the filtered status for DEBOUNCE_MS worth of consecutive cycles. With two sync stages, a clean input step appears on the filtered status exactly DEBOUNCE_CYC+2 clock edges after it is applied.
- R3: A raw excursion shorter than the debounce time leaves the filtered status unchanged.
- R4: A one-cycle line-state-change pulse freezes the filtered status for BLANK_MS worth of cycles, whatever the raw input does in that time. A further pulse during the window restarts the full window.
- R5: Once blanking ends, a raw level that differs from the filtered status is adopted after a full debounce time. The count starts at the end of the window, so the change shows BLANK_CYC+DEBOUNCE_CYC edges after the edge that sampled the pulse.
- R6: The off-hook event is a one-cycle pulse in the first cycle the filtered status reads off-hook. No pulse accompanies a return to on-hook.
- R7: The low-battery select rises exactly LOWBAT_CYC cycles after the filtered status becomes off-hook, provided the status stays off-hook throughout.
- R8: A confirmed on-hook during the hold keeps the high battery selected. The next confirmed off-hook must again wait the full LOWBAT_CYC cycles.
- R9: The low-battery select falls in the same cycle that the filtered status returns to on-hook.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_det_n | input | 1 | Raw loop-supervision level, active low, asynchronous |
| line_state_chg | input | 1 | One-cycle pulse on every line-state change |
| hook_off | output | 1 | Filtered hook status, 1 = off-hook |
| offhook_evt | output | 1 | One-cycle pulse on confirmed off-hook |
| bat_low_sel | output | 1 | 1 selects the low auxiliary battery |

## Verification
The bench builds the block with CLK_PER_MS = 2 and keeps the default millisecond values. This gives a 120-cycle blanking window, a 20-cycle debounce and a 1000-cycle battery hold. At these sizes every window can be probed one cycle before and one cycle after its expected edge. The runs cover a dial break in the middle of the hold, a restarted blanking window, and reversal-style glitches against both hook states, all within a short run.

// File: rtl/hook_pkg.sv
package hook_pkg;
   typedef enum logic {
      HOOK_ON  = 1'b0,
      HOOK_OFF = 1'b1
   } hook_e;

   // width of a counter that must hold values 0..n
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/hook_sync.sv
module hook_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hook_filter.sv
module hook_filter
   import hook_pkg::*;
#(
   parameter int BLANK_CYC = 120,
   parameter int DEB_CYC   = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic off_now,
   input  logic state_chg,
   output logic hook_off,
   output logic off_evt
);
   localparam int BW = cnt_width(BLANK_CYC);
   localparam int DW = cnt_width(DEB_CYC);

   logic [BW-1:0] blank_cnt;
   hook_e         hook_q;
   logic          blanking;
   logic          mismatch;
   logic          update;

   assign blanking = state_chg || (blank_cnt != '0);
   assign mismatch = (off_now != logic'(hook_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  blank_cnt <= '0;
      else if (state_chg)          blank_cnt <= BW'(BLANK_CYC);
      else if (blank_cnt != '0)    blank_cnt <= blank_cnt - 1'b1;
   end

   if (DEB_CYC <= 1) begin : g_nodeb
      assign update = mismatch && !blanking;
   end else begin : g_deb
      logic [DW-1:0] deb_cnt;
      logic          deb_done;
      assign deb_done = (deb_cnt == DW'(DEB_CYC - 1));
      assign update   = mismatch && !blanking && deb_done;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      deb_cnt <= '0;
         else if (blanking || !mismatch)  deb_cnt <= '0;
         else if (deb_done)               deb_cnt <= '0;
         else                             deb_cnt <= deb_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hook_q  <= HOOK_ON;
         off_evt <= 1'b0;
      end else begin
         if (update) hook_q <= off_now ? HOOK_OFF : HOOK_ON;
         off_evt <= update && off_now;
      end
   end

   assign hook_off = (hook_q == HOOK_OFF);
endmodule

// File: rtl/batt_hold_timer.sv
module batt_hold_timer
   import hook_pkg::*;
#(
   parameter int HOLD_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hook_off,
   output logic bat_low
);
   localparam int HW = cnt_width(HOLD_CYC);

   logic [HW-1:0] hold_cnt;
   logic          low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         low_q    <= 1'b0;
      end else if (!hook_off) begin
         hold_cnt <= '0;
         low_q    <= 1'b0;
      end else if (!low_q) begin
         if (hold_cnt == HW'(HOLD_CYC - 1)) begin
            low_q    <= 1'b1;
            hold_cnt <= '0;
         end else begin
            hold_cnt <= hold_cnt + 1'b1;
         end
      end
   end

   // release is combinational so the battery drops with the hook status
   assign bat_low = low_q && hook_off;
endmodule

// File: rtl/line_hook_qual.sv
module line_hook_qual #(
   parameter int CLK_PER_MS  = 1000,
   parameter int BLANK_MS    = 60,
   parameter int DEBOUNCE_MS = 10,
   parameter int LOWBAT_MS   = 500,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic loop_det_n,
   input  logic line_state_chg,
   output logic hook_off,
   output logic offhook_evt,
   output logic bat_low_sel
);
   localparam int BLANK_CYC    = CLK_PER_MS * BLANK_MS;
   localparam int DEBOUNCE_CYC = CLK_PER_MS * DEBOUNCE_MS;
   localparam int LOWBAT_CYC   = CLK_PER_MS * LOWBAT_MS;
   localparam int REVERSAL_MS  = 50;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CLK_PER_MS < 1) begin : g_bad_clk
      $error("CLK_PER_MS must be at least 1");
   end
   if (BLANK_MS < REVERSAL_MS) begin : g_bad_blank
      $error("BLANK_MS must cover a 50 ms reversal glitch");
   end
   if (DEBOUNCE_MS < 1 || LOWBAT_MS < 1) begin : g_bad_win
      $error("debounce and battery hold must be at least 1 ms");
   end

   logic det_n_sync;
   logic off_sync;

   hook_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (loop_det_n),
      .q     (det_n_sync)
   );

   assign off_sync = !det_n_sync;

   hook_filter #(
      .BLANK_CYC (BLANK_CYC),
      .DEB_CYC   (DEBOUNCE_CYC)
   ) u_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .off_now   (off_sync),
      .state_chg (line_state_chg),
      .hook_off  (hook_off),
      .off_evt   (offhook_evt)
   );

   batt_hold_timer #(
      .HOLD_CYC (LOWBAT_CYC)
   ) u_batt (
      .clk      (clk),
      .rst_n    (rst_n),
      .hook_off (hook_off),
      .bat_low  (bat_low_sel)
   );
endmodule

// File: rtl/line_hook_qual_chk.sv
module line_hook_qual_chk
   import hook_pkg::*;
#(
   parameter int BLANK_CYC  = 120,
   parameter int LOWBAT_CYC = 1000
) (
   input logic clk,
   input logic rst_n,
   input logic line_state_chg,
   input logic off_sync,
   input logic hook_off,
   input logic offhook_evt,
   input logic bat_low_sel
);
   localparam int BW = cnt_width(BLANK_CYC);
   localparam int RW = cnt_width(LOWBAT_CYC);

   logic [BW-1:0] blank_left;
   logic [RW-1:0] off_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   blank_left <= '0;
      else if (line_state_chg)      blank_left <= BW'(BLANK_CYC);
      else if (blank_left != '0)    blank_left <= blank_left - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          off_run <= '0;
      else if (!hook_off)                  off_run <= '0;
      else if (off_run != RW'(LOWBAT_CYC)) off_run <= off_run + 1'b1;
   end

   // R2: a new filtered level must match the synchronised input it came from
   p_follow_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hook_off) |-> ($past(off_sync) == hook_off));

   // R4: no change of the filtered status while blanking is in force
   p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_state_chg || blank_left != '0) |=> $stable(hook_off));

   // R6: event pulses exactly on the rise of the filtered status
   p_evt_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hook_off) |-> offhook_evt);
   p_evt_only_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      offhook_evt |-> $rose(hook_off));

   // R7: low battery only after a full unbroken off-hook hold
   p_hold_before_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bat_low_sel) |-> (off_run >= RW'(LOWBAT_CYC)));

   // R9: on-hook never coexists with low battery
   p_onhook_high_bat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hook_off) |-> !bat_low_sel);
endmodule

bind line_hook_qual line_hook_qual_chk #(
   .BLANK_CYC  (BLANK_CYC),
   .LOWBAT_CYC (LOWBAT_CYC)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .line_state_chg (line_state_chg),
   .off_sync       (off_sync),
   .hook_off       (hook_off),
   .offhook_evt    (offhook_evt),
   .bat_low_sel    (bat_low_sel)
);

// File: tb/line_hook_qual_test.sv
module line_hook_qual_test;
   localparam int CLK_PERIOD = 10;
   localparam int CPM   = 2;
   localparam int BLANK = CPM * 60;
   localparam int DEB   = CPM * 10;
   localparam int HOLD  = CPM * 500;

   logic clk = 1'b0;
   logic rst_n;
   logic loop_det_n;
   logic line_state_chg;
   logic hook_off;
   logic offhook_evt;
   logic bat_low_sel;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   line_hook_qual #(
      .CLK_PER_MS  (CPM),
      .BLANK_MS    (60),
      .DEBOUNCE_MS (10),
      .LOWBAT_MS   (500),
      .SYNC_STAGES (2)
   ) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .loop_det_n     (loop_det_n),
      .line_state_chg (line_state_chg),
      .hook_off       (hook_off),
      .offhook_evt    (offhook_evt),
      .bat_low_sel    (bat_low_sel)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic settle_onhook();
      loop_det_n = 1'b1;
      tick(DEB + 5);
   endtask

   task automatic pulse_chg();
      line_state_chg = 1'b1;
      tick(1);
      line_state_chg = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; loop_det_n = 1'b1; line_state_chg = 1'b0;
      tick(3);
      chk("R1", "hook in reset", int'(hook_off), 0);
      chk("R1", "evt in reset", int'(offhook_evt), 0);
      chk("R1", "bat in reset", int'(bat_low_sel), 0);
      rst_n = 1'b1;
      tick(5);
      chk("R1", "hook after reset", int'(hook_off), 0);
      chk("R1", "bat after reset", int'(bat_low_sel), 0);
   endtask

   task automatic t_offhook_and_battery();
      loop_det_n = 1'b0;
      tick(DEB + 1);
      chk("R2", "hook one edge early", int'(hook_off), 0);
      tick(1);
      chk("R2", "hook at debounce edge", int'(hook_off), 1);
      chk("R6", "event on rise", int'(offhook_evt), 1);
      tick(1);
      chk("R6", "event one cycle", int'(offhook_evt), 0);
      tick(HOLD - 2);
      chk("R7", "bat one edge early", int'(bat_low_sel), 0);
      tick(1);
      chk("R7", "bat at hold edge", int'(bat_low_sel), 1);
   endtask

   task automatic t_onhook_return();
      loop_det_n = 1'b1;
      tick(DEB + 1);
      chk("R9", "hook still off", int'(hook_off), 1);
      chk("R9", "bat still low", int'(bat_low_sel), 1);
      tick(1);
      chk("R9", "hook on", int'(hook_off), 0);
      chk("R9", "bat released same cycle", int'(bat_low_sel), 0);
      chk("R6", "no event on return", int'(offhook_evt), 0);
      tick(5);
   endtask

   task automatic t_short_glitch();
      loop_det_n = 1'b0;
      tick(DEB - 1);
      loop_det_n = 1'b1;
      tick(DEB + 5);
      chk("R3", "short closure ignored", int'(hook_off), 0);
      loop_det_n = 1'b0;
      tick(DEB + 5);
      loop_det_n = 1'b1;
      tick(DEB - 1);
      loop_det_n = 1'b0;
      tick(DEB + 5);
      chk("R3", "short break ignored", int'(hook_off), 1);
      settle_onhook();
   endtask

   task automatic t_dial_break();
      loop_det_n = 1'b0;
      tick(DEB + 2);
      chk("R8", "first off-hook", int'(hook_off), 1);
      tick(HOLD / 2);
      loop_det_n = 1'b1;
      tick(DEB + 2);
      chk("R8", "break confirmed", int'(hook_off), 0);
      chk("R8", "bat high during break", int'(bat_low_sel), 0);
      loop_det_n = 1'b0;
      tick(DEB + 2);
      chk("R8", "re-closure", int'(hook_off), 1);
      tick(HOLD - 1);
      chk("R8", "hold restarted", int'(bat_low_sel), 0);
      tick(1);
      chk("R8", "bat after full hold", int'(bat_low_sel), 1);
      settle_onhook();
   endtask

   task automatic t_blank_then_adopt();
      loop_det_n = 1'b0;
      pulse_chg();
      tick(BLANK + DEB - 1);
      chk("R4", "held through blank", int'(hook_off), 0);
      tick(1);
      chk("R5", "adopted after blank+debounce", int'(hook_off), 1);
      settle_onhook();
   endtask

   task automatic t_blank_glitch();
      loop_det_n = 1'b0;
      pulse_chg();
      tick(BLANK - 10);
      loop_det_n = 1'b1;
      tick(DEB + 20);
      chk("R4", "closure glitch masked", int'(hook_off), 0);
      loop_det_n = 1'b0;
      tick(DEB + 5);
      chk("R4", "off-hook before reversal", int'(hook_off), 1);
      loop_det_n = 1'b1;
      pulse_chg();
      tick(CPM * 50);
      loop_det_n = 1'b0;
      tick(BLANK + DEB);
      chk("R4", "reversal open masked", int'(hook_off), 1);
      settle_onhook();
   endtask

   task automatic t_blank_restart();
      loop_det_n = 1'b0;
      pulse_chg();
      tick(BLANK / 2);
      pulse_chg();
      tick(BLANK + DEB - 1);
      chk("R4", "restarted window holds", int'(hook_off), 0);
      tick(1);
      chk("R5", "adopted after restart", int'(hook_off), 1);
      settle_onhook();
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      t_reset();
      t_offhook_and_battery();
      t_onhook_return();
      t_short_glitch();
      t_dial_break();
      t_blank_then_adopt();
      t_blank_glitch();
      t_blank_restart();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         finish_run();
      end
   end
endmodule